// File: doc/BRIEF.md
# ADC Comparator-Mode Control Unit

This block is the digital side of an on-chip analog-to-digital converter peripheral when it runs as a voltage comparator. One bit of a 4-bit control register selects comparator mode. In that mode an 8-bit comparison register sets the code of an internal DAC. The high nibble and the low nibble of that register are loaded in a single transfer from two 4-bit CPU registers. The DAC code n stands for a reference of VDD·n/256. The analog DAC and the comparator themselves are not part of the block. Here they appear only as the `dac_code` output and the one-bit `below_ref` decision input.

A start strobe opens a compare window whose length is a fixed number of machine cycles. Machine cycles are marked by a one-clock enable pulse, `mc_en`. On the last machine cycle of the window the block samples the comparator decision. If the input is below the reference, it sets a completion flag. An interrupt-configuration register decides how software consumes the flag. In one setting the flag raises an interrupt request and is cleared when the interrupt is acknowledged. In the other setting a skip test reads the flag and clears it when the skip is taken.

The conversion-result register of the successive-approximation mode is kept only as far as mode changes affect it. The block also provides its low two bits as a nibble transfer. The comparison register is separate from the conversion-result register and keeps its value across mode changes.

Top module: `adc_cmp_ctrl`

## Requirements
- R1: After reset, `cmp_mode`, `dac_code`, `cmp_flag`, `busy`, `irq_req` and `skip_taken` are all 0.
- R2: A control write (`ctrl_wr`) selects comparator mode when bit 3 of `ctrl_wdata` is 1 and conversion mode when that bit is 0. `cmp_mode` shows the new mode from the next clock.
- R3: `cmp_load` in comparator mode loads `{acc_hi, acc_lo}` into the comparison register (acc_hi is bits 7:4). From the next clock, `dac_code` and `cmp_rd` both show that value.
- R4: In conversion mode, `cmp_load` has no effect and `cmp_rd` reads 0.
- R5: The comparison register keeps its value across a switch to conversion mode and back.
- R6: A start strobe accepted in comparator mode raises `busy` on the next clock. `busy` stays high until the clock edge that carries the 8th `mc_en` pulse after the start, and falls at that edge.
- R7: A start strobe while `busy` is high, or in conversion mode, is ignored: it neither restarts nor extends the window.
- R8: `below_ref` is sampled only at the clock edge that ends the window. If it is 1 there, `cmp_flag` becomes 1. If it is 0, the flag keeps its value. A set wins over a clear in the same cycle.
- R9: With bit 2 of the interrupt-configuration register at 1 (interrupt path), `irq_req` follows `cmp_flag`. An `irq_ack` clears the flag on the next clock.
- R10: With bit 2 at 0 (skip path), `irq_req` is 0 and `irq_ack` has no effect. `skip_taken` is `skip_test` AND the flag, and a taken skip clears the flag on the next clock.
- R11: In conversion mode, `conv_wr` loads the conversion-result register. `res_xfer` is always `{result[1:0], 2'b00}`.
- R12: A control write that leaves comparator mode during a window ends it: `busy` is 0 on the next clock and the flag is not set by that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_en | input | 1 | One-clock pulse per machine cycle |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control data; bit 3 selects comparator mode |
| irq_cfg_wr | input | 1 | Interrupt-configuration write strobe |
| irq_cfg_wdata | input | 4 | Configuration data; bit 2 selects the interrupt path |
| acc_hi | input | 4 | CPU register giving the high nibble |
| acc_lo | input | 4 | CPU register giving the low nibble |
| cmp_load | input | 1 | Transfer the two CPU registers into the comparison register |
| conv_wr | input | 1 | Conversion-result write from the conversion engine |
| conv_wdata | input | 8 | Conversion result value |
| start | input | 1 | Compare start strobe |
| below_ref | input | 1 | Comparator decision: analog input below reference |
| irq_ack | input | 1 | Interrupt taken |
| skip_test | input | 1 | Skip test of the completion flag |
| cmp_mode | output | 1 | 1 in comparator mode |
| dac_code | output | 8 | DAC code, equal to the comparison register |
| cmp_rd | output | 8 | Comparison register read value (0 in conversion mode) |
| res_xfer | output | 4 | Conversion-result low bits moved to the high bits, low bits 0 |
| busy | output | 1 | Compare window in progress |
| cmp_flag | output | 1 | Completion / compare-result flag |
| irq_req | output | 1 | Interrupt request |
| skip_taken | output | 1 | Skip test succeeded |

## Verification
A wrong window count shows at the ports as `busy` falling one or more machine cycles too early or too late. It also shows as a decision sampled on the wrong machine cycle, so the bench drives the opposite level on every other cycle of the window. A mode gate that leaks lets a conversion-mode load change `dac_code` on the next clock. A restart that is not ignored moves the end of `busy`. A consume path that is wired to the wrong selection leaves the flag set, or clears it on the very next clock after a test that should have no effect.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
   localparam int unsigned NIB_W  = 4;
   localparam int unsigned CODE_W = 2 * NIB_W;

   typedef enum logic {
      CONSUME_SKIP = 1'b0,
      CONSUME_IRQ  = 1'b1
   } consume_e;

   typedef enum logic {
      CNT_BINARY = 1'b0,
      CNT_ONEHOT = 1'b1
   } cnt_style_e;
endpackage

// File: rtl/adc_cmp_regs.sv
module adc_cmp_regs
   import adc_cmp_pkg::*;
#(
   parameter int unsigned MODE_BIT  = 3,
   parameter logic [CODE_W-1:0] UNDEF_PAT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [NIB_W-1:0]  ctrl_wdata,
   input  logic              cmp_load,
   input  logic [NIB_W-1:0]  acc_hi,
   input  logic [NIB_W-1:0]  acc_lo,
   input  logic              conv_wr,
   input  logic [CODE_W-1:0] conv_wdata,
   output logic              cmp_mode,
   output logic              mode_leave,
   output logic [CODE_W-1:0] cmp_q,
   output logic [CODE_W-1:0] res_q
);
   if (MODE_BIT >= NIB_W) begin : g_bad_mode_bit
      $error("MODE_BIT outside control register");
   end

   logic [NIB_W-1:0] ctrl_q;
   logic             mode_enter;

   assign cmp_mode   = ctrl_q[MODE_BIT];
   assign mode_enter = ctrl_wr &  ctrl_wdata[MODE_BIT] & ~cmp_mode;
   assign mode_leave = ctrl_wr & ~ctrl_wdata[MODE_BIT] &  cmp_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= ctrl_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cmp_q <= '0;
      else if (cmp_load && cmp_mode) cmp_q <= {acc_hi, acc_lo};
   end

   // conversion result: don't-care pattern on entering comparator mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    res_q <= '0;
      else if (mode_enter)           res_q <= UNDEF_PAT;
      else if (conv_wr && !cmp_mode) res_q <= conv_wdata;
   end

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_load && cmp_mode |=> cmp_q == $past({acc_hi, acc_lo})); // R3
   AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_mode |=> $stable(cmp_q)); // R4
   AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> cmp_mode == $past(ctrl_wdata[MODE_BIT])); // R2
endmodule

// File: rtl/adc_cmp_timer.sv
module adc_cmp_timer
   import adc_cmp_pkg::*;
#(
   parameter int unsigned WINDOW    = 8,
   parameter cnt_style_e  CNT_STYLE = CNT_BINARY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mc_en,
   input  logic start,
   input  logic cmp_mode,
   input  logic abort,
   output logic busy,
   output logic done
);
   localparam int unsigned CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

   if (WINDOW < 2) begin : g_bad_window
      $error("WINDOW must be at least 2");
   end

   logic accept;
   logic last;

   assign accept = start & cmp_mode & ~busy & ~abort;
   assign done   = busy & mc_en & last & ~abort;

   if (CNT_STYLE == CNT_BINARY) begin : g_bin
      logic [CW-1:0] cnt_q;
      assign last = (cnt_q == CW'(WINDOW - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (accept)         cnt_q <= '0;
         else if (busy && mc_en)  cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_onehot
      logic [WINDOW-1:0] pos_q;
      assign last = pos_q[WINDOW-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              pos_q <= '0;
         else if (accept)         pos_q <= WINDOW'(1);
         else if (busy && mc_en)  pos_q <= {pos_q[WINDOW-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy <= 1'b0;
      else if (abort)            busy <= 1'b0;
      else if (accept)           busy <= 1'b1;
      else if (done)             busy <= 1'b0;
   end

   AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start && cmp_mode && !busy && !abort |=> busy); // R6
   AST_DONE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy && mc_en); // R6
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy); // R12
   AST_IDLE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_mode && !busy |=> !busy); // R7
endmodule

// File: rtl/adc_cmp_flag.sv
module adc_cmp_flag
   import adc_cmp_pkg::*;
#(
   parameter int unsigned SEL_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [NIB_W-1:0] cfg_wdata,
   input  logic             done,
   input  logic             below_ref,
   input  logic             irq_ack,
   input  logic             skip_test,
   output logic             flag,
   output logic             irq_req,
   output logic             skip_taken
);
   if (SEL_BIT >= NIB_W) begin : g_bad_sel_bit
      $error("SEL_BIT outside configuration register");
   end

   logic [NIB_W-1:0] cfg_q;
   consume_e         path;
   logic             set_now;
   logic             clr_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= cfg_wdata;
   end

   assign path       = consume_e'(cfg_q[SEL_BIT]);
   assign set_now    = done & below_ref;
   assign irq_req    = (path == CONSUME_IRQ) & flag;
   assign skip_taken = (path == CONSUME_SKIP) & skip_test & flag;
   assign clr_now    = (irq_req & irq_ack) | skip_taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_now) flag <= 1'b1;
      else if (clr_now) flag <= 1'b0;
   end

   AST_SET_ON_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      done && below_ref |=> flag); // R8
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !flag && !(done && below_ref) |=> !flag); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack && !done |=> !flag); // R9
   AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      skip_taken && !done |=> !flag); // R10
   AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req && skip_taken)); // R10
endmodule

// File: rtl/adc_cmp_ctrl.sv
module adc_cmp_ctrl
   import adc_cmp_pkg::*;
#(
   parameter int unsigned WINDOW    = 8,
   parameter int unsigned MODE_BIT  = 3,
   parameter int unsigned SEL_BIT   = 2,
   parameter cnt_style_e  CNT_STYLE = CNT_BINARY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_en,
   input  logic              ctrl_wr,
   input  logic [NIB_W-1:0]  ctrl_wdata,
   input  logic              irq_cfg_wr,
   input  logic [NIB_W-1:0]  irq_cfg_wdata,
   input  logic [NIB_W-1:0]  acc_hi,
   input  logic [NIB_W-1:0]  acc_lo,
   input  logic              cmp_load,
   input  logic              conv_wr,
   input  logic [CODE_W-1:0] conv_wdata,
   input  logic              start,
   input  logic              below_ref,
   input  logic              irq_ack,
   input  logic              skip_test,
   output logic              cmp_mode,
   output logic [CODE_W-1:0] dac_code,
   output logic [CODE_W-1:0] cmp_rd,
   output logic [NIB_W-1:0]  res_xfer,
   output logic              busy,
   output logic              cmp_flag,
   output logic              irq_req,
   output logic              skip_taken
);
   logic              mode_leave;
   logic              done;
   logic [CODE_W-1:0] cmp_q;
   logic [CODE_W-1:0] res_q;

   adc_cmp_regs #(.MODE_BIT(MODE_BIT)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .cmp_load(cmp_load), .acc_hi(acc_hi), .acc_lo(acc_lo),
      .conv_wr(conv_wr), .conv_wdata(conv_wdata),
      .cmp_mode(cmp_mode), .mode_leave(mode_leave),
      .cmp_q(cmp_q), .res_q(res_q)
   );

   adc_cmp_timer #(.WINDOW(WINDOW), .CNT_STYLE(CNT_STYLE)) i_timer (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .start(start),
      .cmp_mode(cmp_mode), .abort(mode_leave),
      .busy(busy), .done(done)
   );

   adc_cmp_flag #(.SEL_BIT(SEL_BIT)) i_flag (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(irq_cfg_wr), .cfg_wdata(irq_cfg_wdata),
      .done(done), .below_ref(below_ref),
      .irq_ack(irq_ack), .skip_test(skip_test),
      .flag(cmp_flag), .irq_req(irq_req), .skip_taken(skip_taken)
   );

   assign dac_code = cmp_q;
   assign cmp_rd   = cmp_mode ? cmp_q : '0;
   assign res_xfer = {res_q[1:0], 2'b00};

   AST_RESULT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_xfer[1:0] == 2'b00); // R11
   AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_mode |-> cmp_rd == '0); // R4
endmodule

// File: tb/test_adc_cmp_ctrl.sv
module test_adc_cmp_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_en = 1'b0;
   logic       ctrl_wr = 1'b0, irq_cfg_wr = 1'b0;
   logic [3:0] ctrl_wdata = '0, irq_cfg_wdata = '0, acc_hi = '0, acc_lo = '0;
   logic       cmp_load = 1'b0, conv_wr = 1'b0, start = 1'b0;
   logic [7:0] conv_wdata = '0;
   logic       below_ref = 1'b0, irq_ack = 1'b0, skip_test = 1'b0;
   logic       cmp_mode, busy, cmp_flag, irq_req, skip_taken;
   logic [7:0] dac_code, cmp_rd;
   logic [3:0] res_xfer;

   int n_tests = 0, n_fail = 0;
   int mc_div = 1, mc_ph = 0;
   bit finished = 0;

   adc_cmp_ctrl i_adc_cmp_ctrl (.*);

   always #4 clk = ~clk;

   // machine-cycle pulse, settled well before each falling edge
   always @(posedge clk) begin
      #2;
      mc_en = (mc_ph == 0);
      mc_ph = (mc_ph + 1 >= mc_div) ? 0 : mc_ph + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_mode(input bit m);
      ctrl_wdata = {m, 3'b000}; ctrl_wr = 1'b1;
      @(negedge clk); ctrl_wr = 1'b0;
   endtask

   task automatic set_path(input bit irq);
      irq_cfg_wdata = {1'b0, irq, 2'b00}; irq_cfg_wr = 1'b1;
      @(negedge clk); irq_cfg_wr = 1'b0;
   endtask

   task automatic load_cmp(input logic [7:0] v);
      acc_hi = v[7:4]; acc_lo = v[3:0]; cmp_load = 1'b1;
      @(negedge clk); cmp_load = 1'b0;
   endtask

   // runs one window; final_v at the last pulse, noise_v elsewhere
   task automatic run_compare(input bit final_v, input bit noise_v, input bit restart);
      int pulses = 0;
      bit e;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R6 busy after start", busy, 1);
      while (pulses < 8) begin
         e = mc_en;
         below_ref = (e && pulses == 7) ? final_v : noise_v;
         start = restart && (pulses == 3);
         @(negedge clk);
         start = 1'b0;
         if (e) pulses++;
         if (pulses < 8) chk(busy == 1'b1, restart ? "R7 busy held" : "R6 busy held", busy, 1);
         else            chk(busy == 1'b0, restart ? "R7 busy end" : "R6 busy end", busy, 0);
      end
      below_ref = 1'b0;
   endtask

   task automatic t_reset;
      chk(cmp_mode == 0 && busy == 0 && cmp_flag == 0, "R1 state", {cmp_mode, busy, cmp_flag}, 0);
      chk(dac_code == 0 && irq_req == 0 && skip_taken == 0, "R1 outputs", dac_code, 0);
   endtask

   task automatic t_load;
      set_mode(1);
      chk(cmp_mode == 1, "R2 mode on", cmp_mode, 1);
      load_cmp(8'hA5);
      chk(dac_code == 8'hA5, "R3 dac", dac_code, 8'hA5);
      chk(cmp_rd == 8'hA5, "R3 read", cmp_rd, 8'hA5);
      set_mode(0);
      chk(cmp_mode == 0, "R2 mode off", cmp_mode, 0);
      chk(cmp_rd == 8'h00, "R4 read gated", cmp_rd, 0);
      load_cmp(8'h3C);
      chk(dac_code == 8'hA5, "R4 load ignored", dac_code, 8'hA5);
      set_mode(1);
      chk(cmp_rd == 8'hA5, "R5 retained", cmp_rd, 8'hA5);
   endtask

   task automatic t_compare;
      set_path(1);
      mc_div = 1;
      run_compare(1'b0, 1'b1, 1'b0);
      chk(cmp_flag == 0, "R8 noise not sampled", cmp_flag, 0);
      mc_div = 3;
      run_compare(1'b1, 1'b0, 1'b0);
      chk(cmp_flag == 1, "R8 set on last", cmp_flag, 1);
      run_compare(1'b0, 1'b0, 1'b0);
      chk(cmp_flag == 1, "R8 kept when above", cmp_flag, 1);
      chk(irq_req == 1, "R9 irq follows", irq_req, 1);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      chk(cmp_flag == 0 && irq_req == 0, "R9 ack clears", cmp_flag, 0);
   endtask

   task automatic t_ignored_start;
      mc_div = 2;
      run_compare(1'b0, 1'b0, 1'b1);
      set_mode(0);
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(busy == 0, "R7 start in conversion", busy, 0);
      set_mode(1);
   endtask

   task automatic t_skip;
      mc_div = 1;
      set_path(0);
      run_compare(1'b1, 1'b1, 1'b0);
      chk(cmp_flag == 1 && irq_req == 0, "R10 no irq", irq_req, 0);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      chk(cmp_flag == 1, "R10 ack ignored", cmp_flag, 1);
      skip_test = 1'b1; #1;
      chk(skip_taken == 1, "R10 skip taken", skip_taken, 1);
      @(negedge clk); skip_test = 1'b0;
      chk(cmp_flag == 0, "R10 skip clears", cmp_flag, 0);
      skip_test = 1'b1; #1;
      chk(skip_taken == 0, "R10 no skip when clear", skip_taken, 0);
      @(negedge clk); skip_test = 1'b0;
   endtask

   task automatic t_abort;
      mc_div = 1;
      start = 1'b1; @(negedge clk); start = 1'b0;
      below_ref = 1'b1;
      repeat (3) @(negedge clk);
      set_mode(0);
      chk(busy == 0, "R12 abort", busy, 0);
      repeat (8) @(negedge clk);
      below_ref = 1'b0;
      chk(cmp_flag == 0, "R12 no flag", cmp_flag, 0);
   endtask

   task automatic t_result;
      conv_wdata = 8'hB6; conv_wr = 1'b1; @(negedge clk); conv_wr = 1'b0;
      chk(res_xfer == 4'b1000, "R11 xfer B6", res_xfer, 4'b1000);
      conv_wdata = 8'h03; conv_wr = 1'b1; @(negedge clk); conv_wr = 1'b0;
      chk(res_xfer == 4'b1100, "R11 xfer 03", res_xfer, 4'b1100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_compare();
      t_ignored_start();
      t_skip();
      t_abort();
      t_result();
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule